// File: doc/BRIEF.md
# Recirculating time-compression sample memory

This block keeps the latest DEPTH samples of a slowly sampled signal and replays all of them, one word per clock, without pause. Each replay pass runs from the oldest stored sample to the newest. Playing back at the fast clock what arrived at the slow sample rate compresses the record in time, which expands its frequency content by the ratio of the two rates. With the default sizes of 600 six-bit words and a 2 MHz clock, one pass takes 300 us and the expansion is about 1333.

A new sample strobe may arrive at any clock. The sample is held and then written into the slot of the oldest word, which is the memory tail, on the last clock of the current pass. The tail then advances by one, so the next pass starts at the word just after the new sample. Two one-clock markers travel with the output stream. One flags the oldest word, where the stream crosses the join between the oldest and newest data. The other flags the newest word, which closes each pass. Downstream weighting logic uses these markers to hide the discontinuity at the join.

Top module: `tcomp_recirc_mem`

## Requirements
- R1: A synchronous reset clears `dac_out`, `tail_mark` and `end_of_pass` to 0 on the next clock and sets the tail to slot 0. The first pass after reset clears every memory word, so every word output in that pass and in the following pass (if nothing has been committed) is 0.
- R2: Output never stops. A new word appears every clock, and consecutive `tail_mark` pulses are exactly DEPTH clocks apart.
- R3: Each pass outputs the stored samples oldest first and newest last. The first word is the one just after the newest sample.
- R4: A strobe on the last clock of a pass is committed at once. Its `sample_data` (passed to `dac_out` bit for bit) becomes the last word of the very next pass.
- R5: With strobes at least DEPTH clocks apart, each strobe is committed exactly once. Each committed sample drops the oldest word, so a pass always shows the last DEPTH committed samples in arrival order.
- R6: `tail_mark` is high for one clock, together with the oldest word of every pass.
- R7: `end_of_pass` is high for one clock, together with the newest word of every pass. It is never high together with `tail_mark`, and it is always followed by `tail_mark` on the next clock.
- R8: A strobe that arrives during the clearing pass after reset is held. It is committed at the end of the following pass, so it first appears as the last word of the third pass.
- R9: The tail changes only when a sample is committed. It moves by exactly one slot and wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast read clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-clock strobe that a new sample is present |
| sample_data | input | WIDTH | New sample value |
| dac_out | output | WIDTH | Replayed word, one per clock, registered |
| tail_mark | output | 1 | High with the oldest word of each pass |
| end_of_pass | output | 1 | High with the newest word of each pass |

## Verification
The bench builds the block with DEPTH = 8 and WIDTH = 6. With these values a pass takes only eight clocks, so dozens of passes and more than two full tail wraps fit in a short run. The short pass also lets the bench place strobes exactly on the last clock of a pass, in the middle of a pass, and inside the clearing pass after reset. The six-bit width is kept at its default so that data values use the full word.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  // Increment an index that cycles over 0..limit-1.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned limit);
    return (idx + 1 >= limit) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/tcr_ring_ram.sv
module tcr_ring_ram #(
  parameter int DEPTH = 600,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with write-first bypass on an address match.
  always_ff @(posedge clk) begin
    if (rst)                      rdata <= '0;
    else if (we && waddr == raddr) rdata <= wdata;
    else                          rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcr_sequencer.sv
module tcr_sequencer #(
  parameter int DEPTH = 600,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [WIDTH-1:0] sample_data,
  output logic [AW-1:0]    rd_addr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [WIDTH-1:0] wr_data,
  output logic [AW-1:0]    tail_idx,
  output logic             tail_mark,
  output logic             end_of_pass
);
  import tcr_pkg::*;

  localparam logic [AW-1:0] LAST_POS = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_X  = (AW+1)'(DEPTH);

  logic [AW-1:0]    pos;
  logic [AW-1:0]    tail;
  logic             clearing;
  logic             held;
  logic [WIDTH-1:0] held_data;
  logic             last_slot;
  logic             commit;
  logic [AW:0]      addr_sum;

  assign last_slot = (pos == LAST_POS);
  assign addr_sum  = {1'b0, tail} + {1'b0, pos};
  assign rd_addr   = (addr_sum >= DEPTH_X) ? AW'(addr_sum - DEPTH_X) : addr_sum[AW-1:0];
  assign commit    = last_slot && !clearing && (sample_valid || held);

  // The clearing pass zeroes each word as it is read; otherwise the
  // only write is the commit into the tail slot on the last clock.
  assign wr_en   = clearing || commit;
  assign wr_addr = clearing ? rd_addr : tail;
  assign wr_data = clearing ? '0 : (sample_valid ? sample_data : held_data);
  assign tail_idx = tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      tail        <= '0;
      clearing    <= 1'b1;
      held        <= 1'b0;
      held_data   <= '0;
      tail_mark   <= 1'b0;
      end_of_pass <= 1'b0;
    end else begin
      pos         <= last_slot ? '0 : pos + 1'b1;
      tail_mark   <= (pos == '0);
      end_of_pass <= last_slot;
      if (last_slot) clearing <= 1'b0;
      if (commit) begin
        tail <= AW'(wrap_inc(int'(tail), DEPTH));
        held <= 1'b0;
      end else if (sample_valid) begin
        held      <= 1'b1;
        held_data <= sample_data;
      end
    end
  end
endmodule

// File: rtl/tcomp_recirc_mem.sv
module tcomp_recirc_mem #(
  parameter int DEPTH = 600,
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [WIDTH-1:0] sample_data,
  output logic [WIDTH-1:0] dac_out,
  output logic             tail_mark,
  output logic             end_of_pass
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]    rd_addr;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_data;
  logic [AW-1:0]    tail_idx;

  tcr_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) seq_i (
    .clk(clk), .rst(rst),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tail_idx(tail_idx), .tail_mark(tail_mark), .end_of_pass(end_of_pass)
  );

  tcr_ring_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ram_i (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(dac_out)
  );
endmodule

// File: rtl/tcomp_recirc_mem_chk.sv
module tcomp_recirc_mem_chk #(
  parameter int DEPTH = 600,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] dac_out,
  input logic             tail_mark,
  input logic             end_of_pass,
  input logic [AW-1:0]    tail_idx
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tail_mark) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dac_out == '0 && !tail_mark && !end_of_pass && tail_idx == '0));

  // R2
  mark_period_chk: assert property (@(posedge clk) disable iff (rst)
    (tail_mark && seen) |-> (gap == (AW+1)'(DEPTH - 1)));

  // R7
  markers_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(tail_mark && end_of_pass));

  // R7
  pass_end_then_mark_chk: assert property (@(posedge clk) disable iff (rst)
    end_of_pass |=> tail_mark);

  // R9
  tail_range_chk: assert property (@(posedge clk) disable iff (rst)
    tail_idx <= LAST_IDX);

  // R9
  tail_moves_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail_idx) |-> end_of_pass);

  // R9
  tail_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail_idx) |->
      tail_idx == (($past(tail_idx) == LAST_IDX) ? '0 : $past(tail_idx) + 1'b1));
endmodule

bind tcomp_recirc_mem tcomp_recirc_mem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .dac_out(dac_out), .tail_mark(tail_mark),
  .end_of_pass(end_of_pass), .tail_idx(tail_idx)
);

// File: tb/tcomp_recirc_mem_test.sv
module tcomp_recirc_mem_test;
  localparam int DEPTH = 8;
  localparam int WIDTH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic [WIDTH-1:0] sample_data = '0;
  logic [WIDTH-1:0] dac_out;
  logic tail_mark, end_of_pass;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit running = 1'b0;

  tcomp_recirc_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_data(sample_data),
    .dac_out(dac_out), .tail_mark(tail_mark), .end_of_pass(end_of_pass)
  );

  always #5 clk = ~clk;

  // Behavioural reference: stored words oldest first in a queue.
  int q[$];
  int m_pos, m_held, m_hdata;
  bit m_clear;
  int exp_dac;
  bit exp_tm, exp_eop;
  int sent[$];

  always @(posedge clk) begin
    if (rst) begin
      q = {};
      for (int i = 0; i < DEPTH; i++) q.push_back(0);
      m_pos = 0; m_clear = 1; m_held = 0; m_hdata = 0;
      exp_dac = 0; exp_tm = 0; exp_eop = 0;
    end else begin
      exp_dac = m_clear ? 0 : q[m_pos];
      exp_tm  = (m_pos == 0);
      exp_eop = (m_pos == DEPTH - 1);
      if (m_pos == DEPTH - 1 && !m_clear && (sample_valid || m_held != 0)) begin
        void'(q.pop_front());
        q.push_back(sample_valid ? int'(sample_data) : m_hdata);
        m_held = 0;
      end else if (sample_valid) begin
        m_held = 1; m_hdata = int'(sample_data);
      end
      if (m_pos == DEPTH - 1) m_clear = 0;
      m_pos = (m_pos == DEPTH - 1) ? 0 : m_pos + 1;
    end
    running = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (running) begin
      chk(int'(dac_out) == exp_dac, "R3 word", int'(dac_out), exp_dac);
      chk(tail_mark == exp_tm, "R6 tail_mark", int'(tail_mark), int'(exp_tm));
      chk(end_of_pass == exp_eop, "R7 end_of_pass", int'(end_of_pass), int'(exp_eop));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic strobe(input int d);
    sample_valid = 1'b1;
    sample_data  = WIDTH'(d);
    @(negedge clk);
    sample_valid = 1'b0;
    sent.push_back(d);
  endtask

  task automatic capture_pass(output int got[DEPTH]);
    do @(negedge clk); while (!tail_mark);
    got[0] = int'(dac_out);
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge clk);
      got[i] = int'(dac_out);
    end
  endtask

  int got[DEPTH];
  int gap_n;

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_out == '0 && !tail_mark && !end_of_pass, "R1 reset outputs",
        int'({dac_out, tail_mark, end_of_pass}), 0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    strobe(42);                          // inside the clearing pass
    capture_pass(got);
    for (int i = 0; i < DEPTH; i++) chk(got[i] == 0, "R1 zero pass", got[i], 0);
    chk(got[DEPTH-1] == 0, "R8 held not yet", got[DEPTH-1], 0);
    capture_pass(got);
    chk(got[DEPTH-1] == 42, "R8 held committed", got[DEPTH-1], 42);
    chk(got[0] == 0, "R3 oldest first", got[0], 0);

    // R2: distance between two tail_mark pulses
    do @(negedge clk); while (!tail_mark);
    gap_n = 0;
    do begin @(negedge clk); gap_n++; end while (!tail_mark);
    chk(gap_n == DEPTH, "R2 pass length", gap_n, DEPTH);

    // R4: strobe on the last clock of a pass (now at pos 1)
    repeat (DEPTH - 2) @(negedge clk);
    strobe(17);
    capture_pass(got);
    chk(got[DEPTH-1] == 17, "R4 boundary newest", got[DEPTH-1], 17);
    chk(got[DEPTH-2] == 42, "R4 previous newest", got[DEPTH-2], 42);

    // R5 and R9: many spaced strobes, tail wraps more than twice
    for (int i = 0; i < 20; i++) begin
      repeat (DEPTH + (i % 6)) @(negedge clk);
      strobe((i * 7 + 3) % 64);
    end
    repeat (2 * DEPTH) @(negedge clk);
    capture_pass(got);
    for (int i = 0; i < DEPTH; i++)
      chk(got[i] == sent[sent.size() - DEPTH + i], "R5 R9 last samples in order",
          got[i], sent[sent.size() - DEPTH + i]);

    // R1 again: reset in mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac_out == '0 && !tail_mark && !end_of_pass, "R1 mid reset outputs",
        int'({dac_out, tail_mark, end_of_pass}), 0);
    rst = 1'b0;
    capture_pass(got);
    capture_pass(got);
    for (int i = 0; i < DEPTH; i++) chk(got[i] == 0, "R1 cleared after reset", got[i], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule